// File: doc/BRIEF.md
# PCI Power-Management Capability Controller

This block holds the power-management capability of a PCI function that only acts as a target. The host reaches it through configuration accesses at two dword slots. Slot 0 is the read-only capability header. Slot 1 is the control/status word, with the power-data byte in its top byte. A preset load port, fed by an external EEPROM reader, fills the fields that software cannot write: PME support, version, the four power-data bytes and the data-scale table. It can also write the PME enable.

On the local side the block gives three things. It pulses an active-low interrupt for one clock whenever the power state changes. It accepts a wake request, which sets the PME status bit. When the function returns from D3hot to D0, it drives a local reset pulse together with a preset-reload request, while PME enable and PME status keep their values. While the function is in D3hot, the memory, I/O and interrupt enables are gated off. The capability pointer output is a fixed constant.

Top module: `pwrmgmt_cap`

## Requirements
- R1: After reset the following hold. The power state is D0 (00). PME enable, PME status and data select are 0. Version is 001 and PME support is 0. lpm_int_n, pme_n and lreset_n are 1, reload_req is 0, and cap_ptr reads 40h.
- R2: A read of cfg_sel 0 returns the following. Bits [7:0] hold the capability ID 01h. Bits [15:8] hold the next pointer NEXT_PTR (48h by default). Bits [31:16] hold the capabilities word: PME support in [31:27], version in [18:16], zeros elsewhere. Writes to cfg_sel 0 are ignored. A read of cfg_sel 2 or 3 returns 0.
- R3: A write to cfg_sel 1 sets the state field from bits [1:0] only when the value is 00 (D0) or 11 (D3hot). Writing 01 or 10 leaves the field unchanged and produces no interrupt.
- R4: When a write changes the state field, lpm_int_n goes low for exactly the one cycle after that write. A write that does not change the state produces no pulse.
- R5: A change from D3hot to D0 drives lreset_n low for SOFT_RST_CYC cycles, starting the cycle after the write. In the first of those cycles reload_req is high for one cycle. PME support, version, power data and scale return to their defaults. PME enable, PME status and data select keep their values.
- R6: A high wake_req sets PME status (control/status bit 15) on the next edge. A host write of 1 to bit 15 clears it, and a write of 0 leaves it set. When a wake request and a clear come in the same cycle, the wake request wins.
- R7: pme_n is low exactly while PME status and PME enable are both 1. PME enable is bit 8 of the control/status word. The host writes it through cfg_sel 1, and the loader writes it through ld_sel 3 from ld_data[8].
- R8: In D3hot, mem_en, io_en and int_out are 0. In D0 they follow cmd_mem_en, cmd_io_en and int_req.
- R9: The data select is control/status bits [12:9]. For select values 0 to 3, cfg_rdata[31:24] of cfg_sel 1 returns byte s of the power-data register, that is bits [8s+7:8s]. For select values 4 to 15 it returns 0.
- R10: The data scale reads at control/status bits [14:13]. For select values 0 to 7 it equals bits [2s+1:2s] of the scale register. For select values 8 to 15 it is 0.
- R11: The loader is addressed by ld_sel when ld_valid is high. ld_sel 0 loads PME support from ld_data[15:11] and version from ld_data[2:0]. ld_sel 1 loads the 32-bit power-data register. ld_sel 2 loads the 16-bit scale register. ld_sel 3 loads PME enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Dword slot: 0 header, 1 control/status |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for cfg_sel |
| ld_valid | input | 1 | Preset load strobe |
| ld_sel | input | 2 | Preset load target |
| ld_data | input | 32 | Preset load data |
| wake_req | input | 1 | Local wake request, sets PME status |
| lpm_int_n | output | 1 | One-cycle active-low power-state-change interrupt |
| lreset_n | output | 1 | Active-low local reset |
| reload_req | output | 1 | One-cycle request to reload presets |
| pme_n | output | 1 | Active-low PME, open-drain style |
| cmd_mem_en | input | 1 | Memory-space enable from the command register |
| cmd_io_en | input | 1 | I/O-space enable from the command register |
| int_req | input | 1 | Function interrupt request |
| mem_en | output | 1 | Gated memory-space enable |
| io_en | output | 1 | Gated I/O-space enable |
| int_out | output | 1 | Gated interrupt |
| cap_ptr | output | 8 | Capabilities pointer, constant 40h |

## Verification
The bench builds the block with its full four-byte power-data table and eight-entry scale table, so all sixteen data-select codes can be swept. The expected byte and scale of each code are computed from shifted load patterns. SOFT_RST_CYC is set to 3, which keeps every cycle of the local reset window visible at the ports. Every legal and illegal state code is written from both D0 and D3hot. The runs also cover PME enable and status orderings, including a wake request and a clear in the same cycle.

// File: rtl/pm_cap_pkg.sv
package pm_cap_pkg;
   typedef enum logic [1:0] {
      PWR_D0    = 2'b00,
      PWR_D3HOT = 2'b11
   } pwr_state_e;

   typedef enum logic [1:0] {
      LD_CAPS  = 2'd0,
      LD_PDATA = 2'd1,
      LD_SCALE = 2'd2,
      LD_PMEEN = 2'd3
   } ld_target_e;

   localparam logic [7:0] PM_CAP_ID = 8'h01;
   localparam int         CSR_W     = 16;
   localparam int         DSEL_W    = 4;
endpackage

// File: rtl/pm_state_ctl.sv
module pm_state_ctl
   import pm_cap_pkg::*;
#(
   parameter int SOFT_RST_CYC = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     csr_wr,
   input  logic [CSR_W-1:0]         csr_wdata,
   input  logic                     ld_pme_en_wr,
   input  logic                     ld_pme_en_val,
   input  logic                     wake_req,
   output pwr_state_e               pwr_st,
   output logic                     pme_en,
   output logic                     pme_sts,
   output logic [DSEL_W-1:0]        data_sel,
   output logic                     st_irq,
   output logic                     soft_rst,
   output logic                     lreset_n
);
   localparam int CNT_W = $clog2(SOFT_RST_CYC + 1);

   if (SOFT_RST_CYC < 1) begin : g_bad_rst
      $error("SOFT_RST_CYC must be at least 1");
   end

   logic [CNT_W-1:0] rst_cnt_q;
   logic [1:0]       req_st;
   logic             req_legal;

   assign req_st    = csr_wdata[1:0];
   assign req_legal = (req_st == PWR_D0) || (req_st == PWR_D3HOT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pwr_st    <= PWR_D0;
         pme_en    <= 1'b0;
         pme_sts   <= 1'b0;
         data_sel  <= '0;
         st_irq    <= 1'b0;
         soft_rst  <= 1'b0;
         rst_cnt_q <= '0;
      end else begin
         st_irq   <= 1'b0;
         soft_rst <= 1'b0;
         if (rst_cnt_q != '0) rst_cnt_q <= rst_cnt_q - 1'b1;
         if (csr_wr) begin
            data_sel <= csr_wdata[12:9];
            if (req_legal && (req_st != pwr_st)) begin
               pwr_st <= pwr_state_e'(req_st);
               st_irq <= 1'b1;
               if (pwr_st == PWR_D3HOT) begin
                  soft_rst  <= 1'b1;
                  rst_cnt_q <= CNT_W'(SOFT_RST_CYC);
               end
            end
         end
         if (csr_wr)            pme_en <= csr_wdata[8];
         else if (ld_pme_en_wr) pme_en <= ld_pme_en_val;
         if (wake_req)                       pme_sts <= 1'b1;
         else if (csr_wr && csr_wdata[15])   pme_sts <= 1'b0;
      end
   end

   assign lreset_n = rst_n && (rst_cnt_q == '0);
endmodule

// File: rtl/pm_preset_regs.sv
module pm_preset_regs
   import pm_cap_pkg::*;
#(
   parameter int         NUM_PDATA = 4,
   parameter int         NUM_SCALE = 8,
   parameter logic [2:0] VER_DFLT  = 3'b001
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   clear,
   input  logic                   ld_valid,
   input  ld_target_e             ld_sel,
   input  logic [31:0]            ld_data,
   output logic [4:0]             pme_sup,
   output logic [2:0]             version,
   output logic [8*NUM_PDATA-1:0] pdata,
   output logic [2*NUM_SCALE-1:0] scale
);
   if (NUM_PDATA < 1 || NUM_PDATA > 4) begin : g_bad_pd
      $error("NUM_PDATA must be 1..4");
   end
   if (NUM_SCALE < 1 || NUM_SCALE > 8) begin : g_bad_sc
      $error("NUM_SCALE must be 1..8");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pme_sup <= '0;
         version <= VER_DFLT;
         pdata   <= '0;
         scale   <= '0;
      end else if (clear) begin
         pme_sup <= '0;
         version <= VER_DFLT;
         pdata   <= '0;
         scale   <= '0;
      end else if (ld_valid) begin
         case (ld_sel)
            LD_CAPS: begin
               pme_sup <= ld_data[15:11];
               version <= ld_data[2:0];
            end
            LD_PDATA: pdata <= ld_data[8*NUM_PDATA-1:0];
            LD_SCALE: scale <= ld_data[2*NUM_SCALE-1:0];
            default:  ;
         endcase
      end
   end
endmodule

// File: rtl/pm_cfg_read.sv
module pm_cfg_read
   import pm_cap_pkg::*;
#(
   parameter int         NUM_PDATA = 4,
   parameter int         NUM_SCALE = 8,
   parameter logic [7:0] NEXT_PTR  = 8'h48
) (
   input  logic [1:0]             cfg_sel,
   input  pwr_state_e             pwr_st,
   input  logic                   pme_en,
   input  logic                   pme_sts,
   input  logic [DSEL_W-1:0]      data_sel,
   input  logic [4:0]             pme_sup,
   input  logic [2:0]             version,
   input  logic [8*NUM_PDATA-1:0] pdata,
   input  logic [2*NUM_SCALE-1:0] scale,
   output logic [31:0]            cfg_rdata
);
   logic [7:0]         byte_hit [NUM_PDATA];
   logic [1:0]         scl_hit  [NUM_SCALE];
   logic [7:0]         pbyte;
   logic [1:0]         pscale;
   logic [CSR_W-1:0]   csr_word;
   logic [15:0]        caps_word;

   for (genvar i = 0; i < NUM_PDATA; i++) begin : g_pd
      assign byte_hit[i] = (data_sel == DSEL_W'(i)) ? pdata[8*i +: 8] : 8'h00;
   end
   for (genvar j = 0; j < NUM_SCALE; j++) begin : g_sc
      assign scl_hit[j] = (data_sel == DSEL_W'(j)) ? scale[2*j +: 2] : 2'b00;
   end

   always_comb begin
      pbyte  = 8'h00;
      pscale = 2'b00;
      for (int i = 0; i < NUM_PDATA; i++) pbyte  = pbyte  | byte_hit[i];
      for (int j = 0; j < NUM_SCALE; j++) pscale = pscale | scl_hit[j];
   end

   assign csr_word  = {pme_sts, pscale, data_sel, pme_en, 6'b0, pwr_st};
   assign caps_word = {pme_sup, 8'h00, version};

   always_comb begin
      case (cfg_sel)
         2'd0:    cfg_rdata = {caps_word, NEXT_PTR, PM_CAP_ID};
         2'd1:    cfg_rdata = {pbyte, 8'h00, csr_word};
         default: cfg_rdata = 32'h0;
      endcase
   end
endmodule

// File: rtl/pwrmgmt_cap.sv
module pwrmgmt_cap
   import pm_cap_pkg::*;
#(
   parameter int         NUM_PDATA    = 4,
   parameter int         NUM_SCALE    = 8,
   parameter int         SOFT_RST_CYC = 4,
   parameter logic [7:0] NEXT_PTR     = 8'h48,
   parameter logic [7:0] CAP_PTR_VAL  = 8'h40,
   parameter logic [2:0] VER_DFLT     = 3'b001
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_wr,
   input  logic [1:0]  cfg_sel,
   input  logic [31:0] cfg_wdata,
   output logic [31:0] cfg_rdata,
   input  logic        ld_valid,
   input  logic [1:0]  ld_sel,
   input  logic [31:0] ld_data,
   input  logic        wake_req,
   output logic        lpm_int_n,
   output logic        lreset_n,
   output logic        reload_req,
   output logic        pme_n,
   input  logic        cmd_mem_en,
   input  logic        cmd_io_en,
   input  logic        int_req,
   output logic        mem_en,
   output logic        io_en,
   output logic        int_out,
   output logic [7:0]  cap_ptr
);
   pwr_state_e               pwr_st;
   logic                     pme_en, pme_sts, st_irq, soft_rst, csr_wr, in_d3;
   logic [DSEL_W-1:0]        data_sel;
   logic [4:0]               pme_sup;
   logic [2:0]               version;
   logic [8*NUM_PDATA-1:0]   pdata;
   logic [2*NUM_SCALE-1:0]   scale;
   ld_target_e               ld_tgt;

   assign csr_wr = cfg_wr && (cfg_sel == 2'd1);
   assign ld_tgt = ld_target_e'(ld_sel);

   pm_state_ctl #(.SOFT_RST_CYC(SOFT_RST_CYC)) u_state (
      .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_wdata(cfg_wdata[CSR_W-1:0]),
      .ld_pme_en_wr(ld_valid && (ld_tgt == LD_PMEEN)), .ld_pme_en_val(ld_data[8]),
      .wake_req(wake_req), .pwr_st(pwr_st), .pme_en(pme_en), .pme_sts(pme_sts),
      .data_sel(data_sel), .st_irq(st_irq), .soft_rst(soft_rst), .lreset_n(lreset_n)
   );

   pm_preset_regs #(.NUM_PDATA(NUM_PDATA), .NUM_SCALE(NUM_SCALE), .VER_DFLT(VER_DFLT)) u_preset (
      .clk(clk), .rst_n(rst_n), .clear(soft_rst), .ld_valid(ld_valid), .ld_sel(ld_tgt),
      .ld_data(ld_data), .pme_sup(pme_sup), .version(version), .pdata(pdata), .scale(scale)
   );

   pm_cfg_read #(.NUM_PDATA(NUM_PDATA), .NUM_SCALE(NUM_SCALE), .NEXT_PTR(NEXT_PTR)) u_read (
      .cfg_sel(cfg_sel), .pwr_st(pwr_st), .pme_en(pme_en), .pme_sts(pme_sts),
      .data_sel(data_sel), .pme_sup(pme_sup), .version(version), .pdata(pdata),
      .scale(scale), .cfg_rdata(cfg_rdata)
   );

   assign in_d3      = (pwr_st == PWR_D3HOT);
   assign mem_en     = cmd_mem_en && !in_d3;
   assign io_en      = cmd_io_en  && !in_d3;
   assign int_out    = int_req    && !in_d3;
   assign lpm_int_n  = !st_irq;
   assign reload_req = soft_rst;
   assign pme_n      = !(pme_sts && pme_en);
   assign cap_ptr    = CAP_PTR_VAL;
endmodule

// File: rtl/pm_cap_chk.sv
module pm_cap_chk
   import pm_cap_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       lpm_int_n,
   input logic       lreset_n,
   input logic       reload_req,
   input logic       pme_n,
   input logic       wake_req,
   input logic       mem_en,
   input logic       io_en,
   input logic       int_out,
   input logic [1:0] st,
   input logic       pme_en,
   input logic       pme_sts
);
   // R4
   lpm_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lpm_int_n |=> lpm_int_n);
   // R4
   lpm_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lpm_int_n) |-> (st != $past(st)));
   // R3
   state_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == 2'b00) || (st == 2'b11));
   // R5
   softrst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lreset_n) |-> (reload_req && st == 2'b00 && $past(st) == 2'b11));
   // R6
   wake_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wake_req |=> pme_sts);
   // R7
   pme_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pme_n |-> (pme_en && pme_sts));
   // R8
   d3_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == 2'b11) |-> (!mem_en && !io_en && !int_out));
endmodule

bind pwrmgmt_cap pm_cap_chk chk_i (
   .clk(clk), .rst_n(rst_n), .lpm_int_n(lpm_int_n), .lreset_n(lreset_n),
   .reload_req(reload_req), .pme_n(pme_n), .wake_req(wake_req), .mem_en(mem_en),
   .io_en(io_en), .int_out(int_out), .st(pwr_st), .pme_en(pme_en), .pme_sts(pme_sts)
);

// File: tb/pwrmgmt_cap_tb_top.sv
`timescale 1ns/1ps
module pwrmgmt_cap_tb_top;
   localparam int          RST_CYC = 3;
   localparam logic [31:0] PD      = 32'h9C5A_3E17;
   localparam logic [15:0] SC      = 16'hB1E4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_wr = 0, ld_valid = 0, wake_req = 0;
   logic cmd_mem_en = 1, cmd_io_en = 1, int_req = 1;
   logic [1:0]  cfg_sel = 0, ld_sel = 0;
   logic [31:0] cfg_wdata = 0, ld_data = 0, cfg_rdata;
   logic lpm_int_n, lreset_n, reload_req, pme_n, mem_en, io_en, int_out;
   logic [7:0] cap_ptr;
   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   pwrmgmt_cap #(.SOFT_RST_CYC(RST_CYC)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .ld_valid(ld_valid), .ld_sel(ld_sel), .ld_data(ld_data),
      .wake_req(wake_req), .lpm_int_n(lpm_int_n), .lreset_n(lreset_n),
      .reload_req(reload_req), .pme_n(pme_n), .cmd_mem_en(cmd_mem_en),
      .cmd_io_en(cmd_io_en), .int_req(int_req), .mem_en(mem_en), .io_en(io_en),
      .int_out(int_out), .cap_ptr(cap_ptr)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] csr_exp(input logic sts, input logic [3:0] ds,
                                           input logic en, input logic [1:0] st,
                                           input logic [31:0] pd, input logic [15:0] sc);
      logic [7:0] b;
      logic [1:0] s;
      b = (ds < 4) ? 8'((pd >> (8 * ds)) & 32'hFF) : 8'h00;
      s = (ds < 8) ? 2'((sc >> (2 * ds)) & 16'h3) : 2'b00;
      return {b, 8'h00, sts, s, ds, en, 6'b0, st};
   endfunction

   task automatic wr_csr(input logic [31:0] d);
      @(negedge clk); cfg_wr = 1; cfg_sel = 2'd1; cfg_wdata = d;
      @(negedge clk); cfg_wr = 0;
   endtask

   task automatic load(input logic [1:0] s, input logic [31:0] d);
      @(negedge clk); ld_valid = 1; ld_sel = s; ld_data = d;
      @(negedge clk); ld_valid = 0;
   endtask

   task automatic rd(input logic [1:0] s, output logic [31:0] d);
      cfg_sel = s; #0.5; d = cfg_rdata;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL R1 watchdog act=running exp=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      logic [1:0]  cur;
      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      rd(2'd1, r); check("R1 csr", r, 32'h0);
      rd(2'd0, r); check("R1 hdr", r, 32'h0001_4801);
      check("R1 pins", {28'h0, lpm_int_n, pme_n, lreset_n, reload_req}, 32'hE);
      check("R1 cap_ptr", {24'h0, cap_ptr}, 32'h40);
      // R11 R2 capabilities load and header
      load(2'd0, (32'h15 << 11) | 32'h2);
      rd(2'd0, r); check("R2 R11 hdr", r, 32'hA802_4801);
      @(negedge clk); cfg_wr = 1; cfg_sel = 2'd0; cfg_wdata = 32'hFFFF_FFFF;
      @(negedge clk); cfg_wr = 0;
      rd(2'd0, r); check("R2 hdr write ignored", r, 32'hA802_4801);
      rd(2'd2, r); check("R2 slot2", r, 32'h0);
      rd(2'd3, r); check("R2 slot3", r, 32'h0);
      load(2'd1, PD);
      load(2'd2, {16'h0, SC});
      // R9 R10 sweep of every select value
      for (int ds = 0; ds < 16; ds++) begin
         wr_csr(32'(ds) << 9);
         check("R4 no pulse same state", {31'h0, lpm_int_n}, 32'h1);
         rd(2'd1, r); check("R9 R10 select sweep", r, csr_exp(0, 4'(ds), 0, 2'b00, PD, SC));
      end
      // R3 R4 R8 state sweep from both states
      cur = 2'b00;
      for (int pass = 0; pass < 2; pass++) begin
         for (int w = 0; w < 4; w++) begin
            logic legal_change;
            legal_change = (w == 0 || w == 3) && (2'(w) != cur);
            if (legal_change && cur == 2'b11) continue;
            wr_csr(32'(w));
            check(legal_change ? "R4 pulse" : "R3 R4 no pulse", {31'h0, lpm_int_n},
                  legal_change ? 32'h0 : 32'h1);
            if (legal_change) cur = 2'(w);
            rd(2'd1, r); check("R3 state field", {30'h0, r[1:0]}, {30'h0, cur});
            @(negedge clk);
            check("R4 pulse width", {31'h0, lpm_int_n}, 32'h1);
            check("R8 gating", {29'h0, mem_en, io_en, int_out},
                  (cur == 2'b11) ? 32'h0 : 32'h7);
         end
      end
      check("R8 in D3hot", {30'h0, cur}, 32'h3);
      // R7 R6 enable and wake while in D3hot
      wr_csr(32'h0000_0103);
      check("R7 en only", {31'h0, pme_n}, 32'h1);
      @(negedge clk); wake_req = 1; @(negedge clk); wake_req = 0;
      check("R7 R6 pme asserted", {31'h0, pme_n}, 32'h0);
      // R5 soft reset on D3hot to D0
      wr_csr(32'h0000_0100);
      check("R5 lreset low", {31'h0, lreset_n}, 32'h0);
      check("R5 reload pulse", {31'h0, reload_req}, 32'h1);
      check("R4 pulse on D0", {31'h0, lpm_int_n}, 32'h0);
      for (int k = 1; k < RST_CYC; k++) begin
         @(negedge clk);
         check("R5 lreset window", {30'h0, lreset_n, reload_req}, 32'h0);
      end
      @(negedge clk);
      check("R5 lreset end", {31'h0, lreset_n}, 32'h1);
      rd(2'd0, r); check("R5 presets default", r, 32'h0001_4801);
      rd(2'd1, r); check("R5 pme kept", r, csr_exp(1, 4'h0, 1, 2'b00, 32'h0, 16'h0));
      check("R5 pme pin kept", {31'h0, pme_n}, 32'h0);
      // R6 write-1-to-clear
      wr_csr(32'h0000_0100);
      rd(2'd1, r); check("R6 write0 no effect", {31'h0, r[15]}, 32'h1);
      wr_csr(32'h0000_8100);
      rd(2'd1, r); check("R6 w1c", {31'h0, r[15]}, 32'h0);
      check("R7 released", {31'h0, pme_n}, 32'h1);
      // R6 set wins over clear
      @(negedge clk); wake_req = 1; cfg_wr = 1; cfg_sel = 2'd1; cfg_wdata = 32'h0000_8100;
      @(negedge clk); wake_req = 0; cfg_wr = 0;
      rd(2'd1, r); check("R6 set wins", {31'h0, r[15]}, 32'h1);
      check("R7 asserted", {31'h0, pme_n}, 32'h0);
      // R7 R11 loader disables enable
      load(2'd3, 32'h0);
      rd(2'd1, r); check("R11 loader pme_en", {31'h0, r[8]}, 32'h0);
      check("R7 disabled by loader", {31'h0, pme_n}, 32'h1);
      load(2'd3, 32'h100);
      check("R7 enabled by loader", {31'h0, pme_n}, 32'h0);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule